// File: doc/BRIEF.md
# Power-Management Control Register with Soft-Off Request

This block is a 16-bit power-management control register. Software reaches it through an I/O block at offsets 4 (low byte) and 5 (high byte). It accepts byte writes to either lane or a full word write.

- **Stored fields.** The register holds an interrupt-enable bit, which is brought out as a level, and a 3-bit sleep-type field. The other non-strobe bits are kept as plain storage.
- **Write-only strobes.** Two bits are strobes that are never stored as readable:
  - The global-release bit, at bit 2, raises a one-clock release pulse when it is written as 1.
  - The sleep-enable bit, at bit 13, raises a one-clock shutdown request. This happens only when the same high-byte write also carries the soft-off sleep-type code.
- **Reads.** A read is combinational. It takes one of three shapes: the whole word, the low byte, or the high byte moved down to bits 7:0.

Powering down and wake handling belong to the logic that consumes the pulses.

Top module: `pm_ctl_reg`

## Requirements
- R1: A write with `wr_be`=2'b01 replaces stored bits 7:0 with `wr_data[7:0]` and leaves bits 15:8 unchanged.
- R2: A write with `wr_be`=2'b10 replaces stored bits 15:8 with `wr_data[15:8]` and leaves bits 7:0 unchanged.
- R3: A write with `wr_be`=2'b11 replaces both bytes at once. A write with `wr_be`=2'b00 changes nothing.
- R4: After a cycle with `rst_n` low, the following hold: a word read returns 16'h0001 (only bit 0 set), `sci_en` is 1, and both pulses are 0. This holds even when a write is presented during that reset cycle.
- R5: Every read returns bit 2 (global release) and bit 13 (sleep enable) as 0.
  - With `rd_word`=1, `rd_data` is the whole masked register.
  - With `rd_word`=0 and `rd_hi`=0, `rd_data` is {8'h00, masked[7:0]}.
  - With `rd_word`=0 and `rd_hi`=1, `rd_data` is {8'h00, masked[15:8]}.
- R6: `shutdown_req` is high for exactly the one cycle after a write that meets all of these conditions:
  - its high lane is enabled (`wr_be[1]`=1);
  - `wr_data[13]`=1;
  - `wr_data[12:10]` equals parameter `SOFF_TYP` (default 3'b000).
  
  Word writes are judged on their full value.
- R7: No shutdown request follows a write when any of the following is true: `wr_data[13]`=0, the sleep-type field differs from `SOFF_TYP`, or only the low lane is enabled.
- R8: A write with `wr_be[0]`=1 and `wr_data[2]`=1 produces `release_req` high for exactly the next cycle. Bit 2 never reads back as 1.
- R9: `sci_en` equals stored bit 0 (interrupt enable) and follows it in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_be | input | 2 | Lane enables: bit 0 low byte (offset 4), bit 1 high byte (offset 5) |
| wr_data | input | 16 | Write data, each byte in its 16-bit position |
| rd_word | input | 1 | 1: word read, 0: byte read |
| rd_hi | input | 1 | Byte read lane select: 1 high byte, 0 low byte |
| rd_data | output | 16 | Masked read data, byte reads zero-extended |
| sci_en | output | 1 | Interrupt-enable level (stored bit 0) |
| shutdown_req | output | 1 | One-cycle soft-off request |
| release_req | output | 1 | One-cycle global-release pulse |

## Verification
The main function is exercised with four kinds of write:
- **Single-lane writes.** Low-only and high-only writes over a known background show that each lane's update is independent of the other.
- **Soft-off matching.** High-byte and word writes are applied with sleep-enable set and clear, and with matching and non-matching sleep types. This separates the soft-off match from a plain sleep-enable check.
- **Wrong lane.** A low-lane write that carries bit 13 in the data shows that the request is gated by the lane.
- **All ones.** All-ones writes followed by reads in all three shapes show that both strobe bits are masked in every read path.

A second instance with a non-default soft-off code shows that the code is taken from the parameter. A reset applied during a write shows that reset takes priority.

// File: rtl/pm_ctl_pkg.sv
// Package: shared constants for the power-management control register.
// Assumes a 16-bit register split into two 8-bit lanes.
package pm_ctl_pkg;
    localparam int PM_W      = 16;
    localparam int PM_LANE_W = 8;
    localparam int PM_LANES  = PM_W / PM_LANE_W;

    // Field positions the strobe logic decodes
    localparam int POS_IRQ_EN = 0;
    localparam int POS_GREL   = 2;
    localparam int POS_TYP_LO = 10;
    localparam int TYP_W      = 3;
    localparam int POS_TYP_HI = POS_TYP_LO + TYP_W - 1;
    localparam int POS_SLPEN  = 13;

    localparam logic [PM_W-1:0] PM_RST_VAL = PM_W'(1) << POS_IRQ_EN;
    localparam logic [PM_W-1:0] PM_WO_MASK =
        (PM_W'(1) << POS_GREL) | (PM_W'(1) << POS_SLPEN);

    typedef enum logic [1:0] {
        RD_LO   = 2'b00,
        RD_HI   = 2'b01,
        RD_WORD = 2'b10
    } rd_shape_e;
endpackage

// File: rtl/pm_ctl_store.sv
// Module: per-lane storage for the control register.
// Each enabled lane is replaced on a write; write-only bits are never kept.
// Assumes synchronous active-low reset.
module pm_ctl_store
    import pm_ctl_pkg::*;
#(
    parameter int W       = PM_W,
    parameter int LANE_W  = PM_LANE_W,
    parameter logic [W-1:0] RST_VAL = PM_RST_VAL,
    parameter logic [W-1:0] WO_MASK = PM_WO_MASK,
    localparam int LANES  = W / LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_be,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     q
);
    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            // Purpose: update one byte lane when it is written
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i*LANE_W +: LANE_W] <= RST_VAL[i*LANE_W +: LANE_W];
                else if (wr_en && wr_be[i])
                    q[i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W]
                                             & ~WO_MASK[i*LANE_W +: LANE_W];
            end
        end
    endgenerate
endmodule

// File: rtl/pm_ctl_strobe.sv
// Module: decodes write data for the soft-off and global-release pulses.
// Each pulse is registered, so it is high for the cycle after the write.
// Assumes the data lanes sit in their 16-bit positions.
module pm_ctl_strobe
    import pm_ctl_pkg::*;
#(
    parameter logic [TYP_W-1:0] SOFF_TYP = 3'b000,
    localparam int LANE_SLP  = POS_SLPEN / PM_LANE_W,
    localparam int LANE_GREL = POS_GREL / PM_LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PM_LANES-1:0] wr_be,
    input  logic [PM_W-1:0]     wr_data,
    output logic                shutdown_req,
    output logic                release_req
);
    logic soff_hit;
    logic grel_hit;

    // Purpose: detect a soft-off request and a release request in this write
    always_comb begin
        soff_hit = wr_en && wr_be[LANE_SLP] && wr_data[POS_SLPEN]
                   && (wr_data[POS_TYP_HI:POS_TYP_LO] == SOFF_TYP);
        grel_hit = wr_en && wr_be[LANE_GREL] && wr_data[POS_GREL];
    end

    // Purpose: register both detections into one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown_req <= 1'b0;
            release_req  <= 1'b0;
        end else begin
            shutdown_req <= soff_hit;
            release_req  <= grel_hit;
        end
    end
endmodule

// File: rtl/pm_ctl_rdmux.sv
// Module: read path; masks the write-only bits and picks the read shape.
// Purely combinational. Byte reads are returned zero-extended in bits 7:0.
module pm_ctl_rdmux
    import pm_ctl_pkg::*;
(
    input  logic [PM_W-1:0] q,
    input  rd_shape_e       shape,
    output logic [PM_W-1:0] rd_data
);
    logic [PM_W-1:0] masked;

    // Purpose: hide the strobe bits and select the requested lane
    always_comb begin
        masked = q & ~PM_WO_MASK;
        unique case (shape)
            RD_WORD: rd_data = masked;
            RD_HI:   rd_data = {{(PM_W-PM_LANE_W){1'b0}}, masked[PM_LANE_W +: PM_LANE_W]};
            default: rd_data = {{(PM_W-PM_LANE_W){1'b0}}, masked[0 +: PM_LANE_W]};
        endcase
    end
endmodule

// File: rtl/pm_ctl_reg.sv
// Module: top of the power-management control register.
// Combines the lane storage, the strobe decode and the read path.
// Assumes one write at most per cycle and a synchronous active-low reset.
module pm_ctl_reg
    import pm_ctl_pkg::*;
#(
    parameter logic [TYP_W-1:0] SOFF_TYP = 3'b000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PM_LANES-1:0] wr_be,
    input  logic [PM_W-1:0]     wr_data,
    input  logic                rd_word,
    input  logic                rd_hi,
    output logic [PM_W-1:0]     rd_data,
    output logic                sci_en,
    output logic                shutdown_req,
    output logic                release_req
);
    logic [PM_W-1:0] ctrl_q;
    rd_shape_e       shape;

    // Purpose: encode the read selects as a read shape
    always_comb begin
        if (rd_word)    shape = RD_WORD;
        else if (rd_hi) shape = RD_HI;
        else            shape = RD_LO;
    end

    pm_ctl_store #(
        .W(PM_W), .LANE_W(PM_LANE_W), .RST_VAL(PM_RST_VAL), .WO_MASK(PM_WO_MASK)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .q(ctrl_q)
    );

    pm_ctl_strobe #(.SOFF_TYP(SOFF_TYP)) strobe_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .shutdown_req(shutdown_req), .release_req(release_req)
    );

    pm_ctl_rdmux rdmux_i (.q(ctrl_q), .shape(shape), .rd_data(rd_data));

    assign sci_en = ctrl_q[POS_IRQ_EN];
endmodule

// File: rtl/pm_ctl_reg_chk.sv
// Module: assertion checker, bound to pm_ctl_reg.
module pm_ctl_reg_chk
    import pm_ctl_pkg::*;
#(
    parameter logic [TYP_W-1:0] SOFF_TYP = 3'b000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [PM_LANES-1:0] wr_be,
    input logic [PM_W-1:0]     wr_data,
    input logic                rd_word,
    input logic [PM_W-1:0]     rd_data,
    input logic [PM_W-1:0]     ctrl_q,
    input logic                shutdown_req,
    input logic                release_req
);
    a_r4_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == PM_RST_VAL && !shutdown_req && !release_req));

    a_r1_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 2'b01) |=> ctrl_q[15:8] == $past(ctrl_q[15:8]));

    a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 2'b10) |=> ctrl_q[7:0] == $past(ctrl_q[7:0]));

    a_r3_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_be == 2'b00) |=> $stable(ctrl_q));

    a_r5_word_masked: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word |-> (!rd_data[POS_GREL] && !rd_data[POS_SLPEN]));

    a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_word |-> rd_data[15:8] == 8'h00);

    a_r6_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(wr_en && wr_be[1] && wr_data[POS_SLPEN]
                               && wr_data[POS_TYP_HI:POS_TYP_LO] == SOFF_TYP));

    a_r7_no_slpen_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[1] && !wr_data[POS_SLPEN]) |=> !shutdown_req);

    a_r8_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |-> $past(wr_en && wr_be[0] && wr_data[POS_GREL]));
endmodule

bind pm_ctl_reg pm_ctl_reg_chk #(.SOFF_TYP(SOFF_TYP)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_word(rd_word), .rd_data(rd_data), .ctrl_q(ctrl_q),
    .shutdown_req(shutdown_req), .release_req(release_req)
);

// File: tb/pm_ctl_reg_tb_top.sv
module pm_ctl_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic        rd_word = 1'b1;
    logic        rd_hi = 1'b0;
    logic [15:0] rd_data, rd_data2;
    logic        sci_en, shutdown_req, release_req;
    logic        sci_en2, shutdown_req2, release_req2;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pm_ctl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_word(rd_word), .rd_hi(rd_hi), .rd_data(rd_data), .sci_en(sci_en),
        .shutdown_req(shutdown_req), .release_req(release_req)
    );

    pm_ctl_reg #(.SOFF_TYP(3'b101)) dut2_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_word(rd_word), .rd_hi(rd_hi), .rd_data(rd_data2), .sci_en(sci_en2),
        .shutdown_req(shutdown_req2), .release_req(release_req2)
    );

    // Vector fields: be, data, rd_word, rd_hi, exp_rd, exp_sd, exp_rel, exp_sci
    localparam int NV = 12;
    localparam logic [38:0] VEC [NV] = '{
        {2'b01, 16'h00FF, 1'b1, 1'b0, 16'h00FB, 1'b0, 1'b1, 1'b1}, // R1 R8
        {2'b10, 16'h5500, 1'b1, 1'b0, 16'h55FB, 1'b0, 1'b0, 1'b1}, // R2
        {2'b00, 16'hFFFF, 1'b0, 1'b1, 16'h0055, 1'b0, 1'b0, 1'b1}, // R3 R5 hi read
        {2'b00, 16'h0000, 1'b0, 1'b0, 16'h00FB, 1'b0, 1'b0, 1'b1}, // R5 lo read
        {2'b11, 16'h2000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R3 R6 R9
        {2'b10, 16'h2400, 1'b1, 1'b0, 16'h0400, 1'b0, 1'b0, 1'b0}, // R7 type mismatch
        {2'b01, 16'h2001, 1'b1, 1'b0, 16'h0401, 1'b0, 1'b0, 1'b1}, // R7 low lane only
        {2'b10, 16'hE300, 1'b1, 1'b0, 16'hC301, 1'b1, 1'b0, 1'b1}, // R6 R5
        {2'b01, 16'h0004, 1'b1, 1'b0, 16'hC300, 1'b0, 1'b1, 1'b0}, // R8 R9
        {2'b11, 16'hFFFF, 1'b0, 1'b1, 16'h00DF, 1'b0, 1'b1, 1'b1}, // R5 R7 R8
        {2'b00, 16'h0000, 1'b1, 1'b0, 16'hDFFB, 1'b0, 1'b0, 1'b1}, // R5 R3
        {2'b11, 16'h0001, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b1}  // R3
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // Reset state, R4
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #5;
        check("R4 reset read", rd_data, 16'h0001);
        check("R4 reset sci", {15'h0, sci_en}, 16'h1);
        check("R4 reset pulses", {14'h0, shutdown_req, release_req}, 16'h0);

        // Table walk: write and read select applied together, sampled after the edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_be   = VEC[i][38:37];
            wr_data = VEC[i][36:21];
            rd_word = VEC[i][20];
            rd_hi   = VEC[i][19];
            @(posedge clk); #5;
            check($sformatf("R1/R2/R3/R5 vec%0d read", i), rd_data, VEC[i][18:3]);
            check($sformatf("R6/R7 vec%0d shutdown", i), {15'h0, shutdown_req}, {15'h0, VEC[i][2]});
            check($sformatf("R8 vec%0d release", i), {15'h0, release_req}, {15'h0, VEC[i][1]});
            check($sformatf("R9 vec%0d sci_en", i), {15'h0, sci_en}, {15'h0, VEC[i][0]});
        end

        // R6: pulse lasts one cycle after a soft-off write followed by idle
        @(negedge clk);
        wr_en = 1'b1; wr_be = 2'b10; wr_data = 16'h2000; rd_word = 1'b1;
        @(posedge clk); #5;
        check("R6 pulse high", {15'h0, shutdown_req}, 16'h1);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #5;
        check("R6 pulse one cycle", {15'h0, shutdown_req}, 16'h0);

        // R6: non-default soft-off code (5) in second instance
        @(negedge clk);
        wr_en = 1'b1; wr_be = 2'b10; wr_data = 16'h3400;
        @(posedge clk); #5;
        check("R6 param code match", {15'h0, shutdown_req2}, 16'h1);
        check("R7 default code mismatch", {15'h0, shutdown_req}, 16'h0);
        @(negedge clk);
        wr_data = 16'h2000;
        @(posedge clk); #5;
        check("R7 param code mismatch", {15'h0, shutdown_req2}, 16'h0);
        check("R6 default code match", {15'h0, shutdown_req}, 16'h1);

        // R4: reset dominates a simultaneous write
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; wr_be = 2'b11; wr_data = 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0; rd_word = 1'b1;
        #1;
        check("R4 reset over write read", rd_data, 16'h0001);
        check("R4 reset over write pulses", {14'h0, shutdown_req, release_req}, 16'h0);
        check("R4 reset over write sci", {15'h0, sci_en}, 16'h1);

        done = 1'b1;
        finish_run();
    end
endmodule